// File: doc/BRIEF.md
# Programmable ADC Step Sequencer

This block drives an external successive-approximation converter from a table of sixteen programmable steps. Each step names one of eight analog inputs and carries its own open delay, sample width and averaging count. When a round is started, the block walks the enabled steps from the lowest index to the highest. For each step it waits out the open delay, then pulses start-of-conversion for the sample width. It gathers as many conversion results as the averaging count asks for and then offers one averaged result, tagged with the step index, on a valid/ready output.

A touchscreen mode places a charge phase of programmable length at the start of every round. The pen-down input is sampled in the last cycle of that phase. While the pen is down the round runs normally. When the pen is up, the steps held for touchscreen readouts are skipped: N for X, N for Y and two for pressure, always taken from index 0 upward. A one-cycle pen-up flag is raised in that case. Steps above the reserved ones remain free for general channels. In continuous mode a new round begins in the same cycle the previous one completes.

Top module: `adc_step_seq`

## Requirements
- R1: While `cfg_we` is high at a clock edge, the input select, open delay, sample width and averaging value on the `cfg_*` inputs are stored for step `cfg_idx`. That input select appears on `adc_ain` for as long as start-of-conversion is high during that step.
- R2: Steps whose bit in `step_en` is set run in strictly ascending index order, and disabled steps take no cycles. The cycle after an output handshake belongs to the next enabled step, so `out_valid` is low in that cycle.
- R3: The cycle in which a step is entered counts as cycle 0. `adc_soc` first rises in cycle open_delay + 1, and `adc_ain` holds steady for as long as `adc_soc` is high.
- R4: Each conversion holds `adc_soc` high for exactly `samp` cycles, or for one cycle when `samp` is 0. The block then waits for `adc_done`, and ignores it at any other time.
- R5: The averaging value A sets the conversion count C to the largest power of two not above A, capped at 16. A value of 0 gives C = 1. The step makes C conversions, and each one after the first raises `adc_soc` in the cycle after the previous `adc_done`. The output value is the sum of the C results divided by C, rounded down.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_step` and `out_data` hold steady and no conversion starts.
- R7: A `start` pulse seen while idle begins a round. After the last enabled step is accepted, the block goes idle if `cont` is low. If `cont` is high it begins the next round in the same cycle.
- R8: With `ts_en` high, every round opens with a charge phase lasting `ts_charge` + 1 cycles. During that phase `adc_soc` and `out_valid` stay low, and `pen_down` is sampled in the final cycle of the phase.
- R9: If `pen_down` is low at that sample, the steps with index below 2·`ts_reads` + 2 are skipped for this round and `pen_up` is high for exactly the one following cycle. If `pen_down` is high, every enabled step runs and `pen_up` stays low.
- R10: After reset, `out_valid`, `adc_soc` and `pen_up` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Step table write strobe |
| cfg_idx | input | 4 | Step index to write |
| cfg_ain | input | 3 | Analog input select for the step |
| cfg_open | input | 18 | Open delay in cycles |
| cfg_samp | input | 8 | Sample width in cycles |
| cfg_avg | input | 5 | Averaging value |
| step_en | input | 16 | Per-step enable mask |
| start | input | 1 | Begin a round when idle |
| cont | input | 1 | Continuous mode |
| ts_en | input | 1 | Touchscreen mode |
| ts_reads | input | 3 | Readouts per coordinate |
| ts_charge | input | 16 | Charge phase length |
| pen_down | input | 1 | Pen contact sense |
| adc_ain | output | 3 | Analog input select to the converter |
| adc_soc | output | 1 | Start-of-conversion |
| adc_done | input | 1 | Conversion done strobe |
| adc_data | input | 12 | Conversion result |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumed |
| out_step | output | 4 | Step index of the result |
| out_data | output | 12 | Averaged result |
| pen_up | output | 1 | One-cycle pen-up flag |

## Verification
A corrupted delay counter moves the rising or falling edge of `adc_soc` by at least one cycle, and the per-cycle reference comparison flags that in the same cycle. A wrong accumulator or conversion count surfaces in `out_data` or in the timing of `out_valid` as soon as the affected step finishes. A bad step pointer or skip bound shows up as a wrong `out_step` or a missing index in the accepted sequence by the end of the round. A mistimed pen evaluation shifts `pen_up` or the first step after the charge phase right away.

// File: rtl/adc_step_seq.sv
`timescale 1ns/1ps
module adc_step_seq #(
  parameter int NSTEP  = 16,
  parameter int IDX_W  = $clog2(NSTEP),
  parameter int AIN_W  = 3,
  parameter int OPEN_W = 18,
  parameter int SAMP_W = 8,
  parameter int AVG_W  = 5,
  parameter int CHG_W  = 16,
  parameter int TSN_W  = 3,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [AIN_W-1:0]  cfg_ain,
  input  logic [OPEN_W-1:0] cfg_open,
  input  logic [SAMP_W-1:0] cfg_samp,
  input  logic [AVG_W-1:0]  cfg_avg,
  input  logic [NSTEP-1:0]  step_en,
  input  logic              start,
  input  logic              cont,
  input  logic              ts_en,
  input  logic [TSN_W-1:0]  ts_reads,
  input  logic [CHG_W-1:0]  ts_charge,
  input  logic              pen_down,
  output logic [AIN_W-1:0]  adc_ain,
  output logic              adc_soc,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_step,
  output logic [RES_W-1:0]  out_data,
  output logic              pen_up
);
  localparam int CNT_A = (OPEN_W > CHG_W) ? OPEN_W : CHG_W;
  localparam int CNT_W = (CNT_A > SAMP_W) ? CNT_A : SAMP_W;
  localparam int SHF_MAX = 4;
  localparam int ACC_W = RES_W + SHF_MAX;
  localparam int REP_W = SHF_MAX + 1;

  typedef enum logic [2:0] {S_IDLE, S_CHG, S_OPEN, S_SAMP, S_WAIT, S_OUT} st_t;

  logic [AIN_W-1:0]  t_ain  [NSTEP];
  logic [OPEN_W-1:0] t_open [NSTEP];
  logic [SAMP_W-1:0] t_samp [NSTEP];
  logic [2:0]        t_shf  [NSTEP];

  st_t              st, st_n;
  logic [IDX_W-1:0] cur, cur_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [REP_W-1:0] rep, rep_n;
  logic [ACC_W-1:0] acc, acc_n;
  logic             pu_n;
  logic [IDX_W:0]   tgt;
  logic             rs, end_r;
  logic [2:0]       wr_shf;
  logic [IDX_W:0]   ts_res;
  logic [CNT_W-1:0] samp_ld;
  logic [REP_W-1:0] rep_last;

  function automatic logic [IDX_W:0] pick(input logic [NSTEP-1:0] m, input logic [IDX_W:0] lo);
    pick = '0;
    for (int i = NSTEP - 1; i >= 0; i--)
      if (m[i] && i >= int'(lo)) pick = {1'b1, IDX_W'(i)};
  endfunction

  assign wr_shf   = cfg_avg[AVG_W-1] ? 3'd4 : cfg_avg[3] ? 3'd3 : cfg_avg[2] ? 3'd2 :
                    cfg_avg[1] ? 3'd1 : 3'd0;
  assign ts_res   = (IDX_W+1)'({ts_reads, 1'b0}) + (IDX_W+1)'(2);
  assign samp_ld  = (t_samp[cur] == '0) ? '0 : CNT_W'(t_samp[cur] - 1'b1);
  assign rep_last = REP_W'((REP_W'(1) << t_shf[cur]) - REP_W'(1));

  assign adc_ain   = t_ain[cur];
  assign adc_soc   = (st == S_SAMP);
  assign out_valid = (st == S_OUT);
  assign out_step  = cur;
  assign out_data  = RES_W'(acc >> t_shf[cur]);

  always_comb begin
    st_n  = st;
    cur_n = cur;
    cnt_n = cnt;
    rep_n = rep;
    acc_n = acc;
    pu_n  = 1'b0;
    tgt   = '0;
    rs    = 1'b0;
    end_r = 1'b0;
    case (st)
      S_IDLE: rs = start;
      S_CHG:
        if (cnt == '0) begin
          pu_n = !pen_down;
          tgt  = pick(step_en, pen_down ? '0 : ts_res);
          end_r = !tgt[IDX_W];
        end else cnt_n = cnt - 1'b1;
      S_OPEN:
        if (cnt == '0) begin
          st_n  = S_SAMP;
          cnt_n = samp_ld;
        end else cnt_n = cnt - 1'b1;
      S_SAMP:
        if (cnt == '0) st_n = S_WAIT;
        else cnt_n = cnt - 1'b1;
      S_WAIT:
        if (adc_done) begin
          acc_n = acc + ACC_W'(adc_data);
          if (rep == rep_last) st_n = S_OUT;
          else begin
            rep_n = rep + 1'b1;
            st_n  = S_SAMP;
            cnt_n = samp_ld;
          end
        end
      S_OUT:
        if (out_ready) begin
          tgt   = pick(step_en, {1'b0, cur} + 1'b1);
          end_r = !tgt[IDX_W];
        end
      default: st_n = S_IDLE;
    endcase
    if (end_r) begin
      if (cont) rs = 1'b1;
      else st_n = S_IDLE;
    end
    if (rs) begin
      if (ts_en) begin
        st_n  = S_CHG;
        cnt_n = CNT_W'(ts_charge);
      end else begin
        tgt = pick(step_en, '0);
        if (!tgt[IDX_W]) st_n = S_IDLE;
      end
    end
    if (tgt[IDX_W]) begin
      st_n  = S_OPEN;
      cur_n = tgt[IDX_W-1:0];
      cnt_n = CNT_W'(t_open[tgt[IDX_W-1:0]]);
      rep_n = '0;
      acc_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur    <= '0;
      cnt    <= '0;
      rep    <= '0;
      acc    <= '0;
      pen_up <= 1'b0;
      for (int i = 0; i < NSTEP; i++) begin
        t_ain[i]  <= '0;
        t_open[i] <= '0;
        t_samp[i] <= '0;
        t_shf[i]  <= '0;
      end
    end else begin
      st     <= st_n;
      cur    <= cur_n;
      cnt    <= cnt_n;
      rep    <= rep_n;
      acc    <= acc_n;
      pen_up <= pu_n;
      if (cfg_we) begin
        t_ain[cfg_idx]  <= cfg_ain;
        t_open[cfg_idx] <= cfg_open;
        t_samp[cfg_idx] <= cfg_samp;
        t_shf[cfg_idx]  <= wr_shf;
      end
    end
  end
endmodule

// File: rtl/adc_step_seq_chk.sv
`timescale 1ns/1ps
module adc_step_seq_chk #(
  parameter int IDX_W = 4,
  parameter int AIN_W = 3,
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AIN_W-1:0] adc_ain,
  input logic             adc_soc,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_step,
  input logic [RES_W-1:0] out_data,
  input logic             pen_up
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_step) && $stable(out_data));
  // R2
  out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);
  // R3
  ain_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_soc |-> $stable(adc_ain));
  // R9
  pen_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up |=> !pen_up);
  // R8
  pen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up |-> !adc_soc && !out_valid);
  // R4
  soc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_soc |-> !out_valid);
endmodule

bind adc_step_seq adc_step_seq_chk #(.IDX_W(IDX_W), .AIN_W(AIN_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_ain(adc_ain), .adc_soc(adc_soc), .out_valid(out_valid),
  .out_ready(out_ready), .out_step(out_step), .out_data(out_data), .pen_up(pen_up));

// File: tb/adc_step_seq_bench.sv
`timescale 1ns/1ps
module adc_step_seq_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_idx = 0;
  logic [2:0] cfg_ain = 0;
  logic [17:0] cfg_open = 0;
  logic [7:0] cfg_samp = 0;
  logic [4:0] cfg_avg = 0;
  logic [15:0] step_en = 0;
  logic start = 0, cont = 0, ts_en = 0, pen_down = 0;
  logic [2:0] ts_reads = 3'd2;
  logic [15:0] ts_charge = 16'd10;
  logic [2:0] adc_ain;
  logic adc_soc, adc_done = 0;
  logic [11:0] adc_data = 0;
  logic out_valid, out_ready = 1;
  logic [3:0] out_step;
  logic [11:0] out_data;
  logic pen_up;

  adc_step_seq u_adc_step_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_ain(cfg_ain),
    .cfg_open(cfg_open), .cfg_samp(cfg_samp), .cfg_avg(cfg_avg), .step_en(step_en),
    .start(start), .cont(cont), .ts_en(ts_en), .ts_reads(ts_reads), .ts_charge(ts_charge),
    .pen_down(pen_down), .adc_ain(adc_ain), .adc_soc(adc_soc), .adc_done(adc_done),
    .adc_data(adc_data), .out_valid(out_valid), .out_ready(out_ready), .out_step(out_step),
    .out_data(out_data), .pen_up(pen_up));

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0, model_on = 0, stall = 0;
  int m_ain[16], m_open[16], m_samp[16], m_cnt[16];
  int seen[$];
  int pu_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // converter stand-in
  int lat = 0, conv = 0;
  bit prev_soc = 0;
  logic [2:0] ain_l = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    adc_done = 0;
    if (prev_soc && !adc_soc) lat = 1 + (conv % 3);
    else if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        adc_done = 1;
        adc_data = 12'((ain_l * 509 + conv * 97 + 11) % 4096);
        conv++;
      end
    end
    prev_soc = adc_soc;
    if (adc_soc) ain_l = adc_ain;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) seen.push_back(int'(out_step));
    if (rst_n && pen_up) pu_cnt++;
  end

  // behavioural reference
  bit e_soc = 0, e_valid = 0, e_pu = 0;
  int e_ain = 0, e_step = 0, e_data = 0;
  string phase = "R10";
  bit s_done, s_rdy, s_pen, s_start, s_cont, s_ts;
  int s_data;
  logic [15:0] s_mask;

  task automatic tick();
    @(posedge clk);
    s_done = adc_done; s_data = int'(adc_data); s_rdy = out_ready; s_pen = pen_down;
    s_start = start; s_cont = cont; s_ts = ts_en; s_mask = step_en;
    #1;
    e_pu = 0;
  endtask

  task automatic do_step(input int i);
    int sum;
    phase = "R3"; e_ain = m_ain[i]; e_valid = 0;
    repeat (m_open[i] + 1) tick();
    sum = 0;
    for (int r = 0; r < m_cnt[i]; r++) begin
      phase = "R4"; e_soc = 1;
      repeat (m_samp[i] == 0 ? 1 : m_samp[i]) tick();
      e_soc = 0; phase = "R5";
      do tick(); while (!s_done);
      sum += s_data;
    end
    phase = "R6"; e_valid = 1; e_step = i; e_data = sum / m_cnt[i];
    do tick(); while (!s_rdy);
    e_valid = 0; phase = "R7";
  endtask

  task automatic run_round();
    int lo = 0;
    if (s_ts) begin
      phase = "R8"; e_soc = 0; e_valid = 0;
      repeat (int'(ts_charge) + 1) tick();
      lo = s_pen ? 0 : 2 * int'(ts_reads) + 2;
      e_pu = !s_pen;
    end
    for (int i = lo; i < 16; i++) if (s_mask[i]) do_step(i);
  endtask

  initial begin
    wait (model_on);
    forever begin
      phase = "R7";
      do tick(); while (!s_start);
      forever begin
        run_round();
        if (!s_cont) break;
      end
    end
  end

  always @(negedge clk) if (rst_n && model_on) begin
    chk(adc_soc === e_soc, phase, adc_soc, e_soc);
    if (e_soc) chk(adc_ain === 3'(e_ain), "R1", adc_ain, e_ain);
    chk(out_valid === e_valid, phase, out_valid, e_valid);
    if (e_valid && out_valid) begin
      chk(out_step == 4'(e_step), "R2", out_step, e_step);
      chk(out_data == 12'(e_data), "R5", out_data, e_data);
    end
    chk(pen_up === e_pu, "R9", pen_up, e_pu);
  end

  task automatic prog(input int i, input int a, input int o, input int s, input int v);
    int c = 1;
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(i); cfg_ain = 3'(a); cfg_open = 18'(o); cfg_samp = 8'(s); cfg_avg = 5'(v);
    @(negedge clk);
    cfg_we = 0;
    while (c * 2 <= v && c < 16) c = c * 2;
    m_ain[i] = a; m_open[i] = o; m_samp[i] = s; m_cnt[i] = c;
  endtask

  task automatic run_case(input logic [15:0] mask, input bit ts, input bit pen, input bit stl,
                          input int rounds, input string req);
    int exp[$];
    int per = 0, lo;
    lo = (ts && !pen) ? 2 * int'(ts_reads) + 2 : 0;
    for (int i = lo; i < 16; i++) if (mask[i]) per++;
    for (int r = 0; r < rounds; r++)
      for (int i = lo; i < 16; i++) if (mask[i]) exp.push_back(i);
    @(negedge clk);
    step_en = mask; ts_en = ts; pen_down = pen; stall = stl; cont = (rounds > 1);
    seen.delete(); pu_cnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    while (seen.size() < (rounds - 1) * per) @(negedge clk);
    cont = 0;
    while (seen.size() < exp.size()) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(seen.size() == exp.size(), req, seen.size(), exp.size());
    for (int k = 0; k < exp.size() && k < seen.size(); k++) chk(seen[k] == exp[k], req, seen[k], exp[k]);
    chk(pu_cnt == ((ts && !pen) ? rounds : 0), "R9", pu_cnt, (ts && !pen) ? rounds : 0);
    chk(out_valid == 0 && adc_soc == 0, "R7", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10", out_valid, 0);
    chk(adc_soc == 0, "R10", adc_soc, 0);
    chk(pen_up == 0, "R10", pen_up, 0);
    rst_n = 1;
    for (int i = 0; i < 16; i++)
      prog(i, (i * 3 + 1) % 8, (i == 5) ? 300 : i % 4, i % 3, (i * 7) % 17);
    model_on = 1;
    repeat (3) @(negedge clk);
    run_case(16'b1000_0010_0001_1010, 0, 0, 0, 1, "R2");
    run_case(16'hFFFF, 0, 0, 1, 1, "R6");
    run_case(16'h0041, 0, 0, 0, 3, "R7");
    run_case(16'h00FF, 1, 1, 0, 1, "R8");
    run_case(16'h00FF, 1, 0, 1, 2, "R9");
    run_case(16'h8000, 0, 0, 0, 1, "R2");
    prog(15, 6, 0, 0, 31);
    run_case(16'h8000, 0, 0, 1, 1, "R5");
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule